// File: doc/BRIEF.md
# Constant-Step Closed-Form Accumulator

This block produces the terms of a running sum in which a fixed step is added again and again to a starting value. A recurrent form, where each term waits for the previous one to leave a multi-cycle adder, would let a new term begin only once per adder latency. This block avoids that wait. It forms every term directly as the start value plus (k+1) times the step, so one term enters the adder on every clock and the adder pipeline stays full.

A run begins when the block accepts a start strobe. On that edge it captures a start value, a step and a term count. It then issues one term per cycle into an adder pipeline whose depth is a parameter, standing in for a slow adder. Each result leaves the pipeline with a valid flag and its term index. A busy flag covers the whole run, including the pipeline drain. A one-cycle done pulse closes the run. All arithmetic is two's complement fixed point, and the result is wide enough that no term can overflow.

Two variants produce the multiple of the step. One keeps a running multiple that gains one step per issue cycle. The other multiplies (k+1) by the step directly. A parameter chooses between them.

Top module: `const_step_accum`

## Requirements
- R1: Result k equals start + (k+1)*step, with start and step as DATA_W-bit signed values. It is given as a signed value of DATA_W + clog2(MAX_COUNT+1) bits, so it never wraps for any legal count.
- R2: Within a run of N terms, results arrive on N consecutive cycles with indices 0, 1, ..., N-1 and no idle cycle between them.
- R3: Result 0 is valid exactly ADD_LAT cycles after the clock edge that accepts the start strobe. Result k follows k cycles later.
- R4: While busy_o is high, a start strobe has no effect. The running sequence of results, its timing and its done pulse stay unchanged.
- R5: done_o is high for exactly one cycle: the cycle after the last result is valid. busy_o is high from the accepting edge until that cycle and low during it.
- R6: A start strobe with a count of 0, or a count above MAX_COUNT, is ignored. No result, no busy and no done follow.
- R7: Start value, step and count are captured only on the accepting edge. Later changes on those inputs do not alter the run.
- R8: While reset is low, and on the first cycle after it, res_valid_o, busy_o and done_o are 0. A reset in the middle of a run ends that run with no further results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| count_i | input | CNT_W | Number of terms in the run (1..MAX_COUNT) |
| base_i | input | DATA_W | Signed start value |
| step_i | input | DATA_W | Signed constant step |
| res_valid_o | output | 1 | A result is present this cycle |
| res_index_o | output | CNT_W | Term index k of the present result |
| res_data_o | output | RES_W | Signed result start + (k+1)*step |
| busy_o | output | 1 | Run in progress, including pipeline drain |
| done_o | output | 1 | One-cycle pulse after the last result |

## Verification
The checker rebuilds the accepted operands from the ports alone. It treats an accept as a start strobe seen while busy_o is low with a count in range. This assumes reset is asserted before the first start and that inputs settle before each rising edge. The bench therefore drives every input on the falling edge. It holds a start high for one edge only, except when it deliberately raises start during a run to exercise R4 and R7. It never issues a count that the block would clamp silently: out-of-range counts appear only in the R6 tests, which expect nothing to happen.

// File: rtl/stepacc_pkg.sv
package stepacc_pkg;

   // How the multiple (k+1)*step is formed for each issued term.
   typedef enum logic {
      MUL_RUNNING = 1'b0,   // running register, one step added per issue
      MUL_DIRECT  = 1'b1    // index-plus-one times step, combinational
   } mul_style_e;

   // Bits needed to hold counts 0..max_count.
   function automatic int cnt_bits(input int max_count);
      return $clog2(max_count + 1);
   endfunction

endpackage

// File: rtl/stepacc_sequencer.sv
module stepacc_sequencer #(
   parameter int DATA_W    = 16,
   parameter int MAX_COUNT = 64,
   parameter int CNT_W     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [DATA_W-1:0] base_i,
   input  logic [DATA_W-1:0] step_i,
   input  logic              drain_last_i,
   output logic              accept_o,
   output logic [DATA_W-1:0] base_q_o,
   output logic [DATA_W-1:0] step_q_o,
   output logic [CNT_W-1:0]  cnt_q_o,
   output logic              issue_vld_o,
   output logic [CNT_W-1:0]  issue_idx_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_COUNT);
   localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

   logic              busy_q;
   logic              done_q;
   logic              issue_vld_q;
   logic [CNT_W-1:0]  issue_idx_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] base_q;
   logic [DATA_W-1:0] step_q;
   logic              count_ok;
   logic              issue_last;

   assign count_ok   = (count_i != '0) && (count_i <= CNT_LIMIT);
   assign accept_o   = start_i && !busy_q && count_ok;
   assign issue_last = issue_vld_q && (issue_idx_q == cnt_q - CNT_ONE);

   // Run control: operands are latched once and held for the whole run.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         done_q      <= 1'b0;
         issue_vld_q <= 1'b0;
         issue_idx_q <= '0;
         cnt_q       <= '0;
         base_q      <= '0;
         step_q      <= '0;
      end else begin
         done_q <= drain_last_i;
         if (accept_o) begin
            busy_q      <= 1'b1;
            issue_vld_q <= 1'b1;
            issue_idx_q <= '0;
            cnt_q       <= count_i;
            base_q      <= base_i;
            step_q      <= step_i;
         end else begin
            if (issue_vld_q) begin
               if (issue_last) begin
                  issue_vld_q <= 1'b0;
               end else begin
                  issue_idx_q <= issue_idx_q + CNT_ONE;
               end
            end
            if (drain_last_i) begin
               busy_q <= 1'b0;
            end
         end
      end
   end

   assign base_q_o    = base_q;
   assign step_q_o    = step_q;
   assign cnt_q_o     = cnt_q;
   assign issue_vld_o = issue_vld_q;
   assign issue_idx_o = issue_idx_q;
   assign busy_o      = busy_q;
   assign done_o      = done_q;

endmodule

// File: rtl/stepacc_multiple.sv
module stepacc_multiple
   import stepacc_pkg::*;
#(
   parameter int         DATA_W    = 16,
   parameter int         CNT_W     = 7,
   parameter int         RES_W     = 23,
   parameter mul_style_e MUL_STYLE = MUL_RUNNING
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    accept_i,
   input  logic [DATA_W-1:0]       step_i,
   input  logic [DATA_W-1:0]       step_q_i,
   input  logic                    issue_vld_i,
   input  logic [CNT_W-1:0]        issue_idx_i,
   output logic signed [RES_W-1:0] mult_o
);

   localparam int EXT_W = RES_W - DATA_W;

   logic signed [RES_W-1:0] step_in_x;
   logic signed [RES_W-1:0] step_q_x;

   assign step_in_x = {{EXT_W{step_i[DATA_W-1]}}, step_i};
   assign step_q_x  = {{EXT_W{step_q_i[DATA_W-1]}}, step_q_i};

   generate
      if (MUL_STYLE == MUL_RUNNING) begin : g_running
         // The multiple tracks the issue index: step at index 0, one more step per issue.
         logic signed [RES_W-1:0] mult_q;
         logic                    unused_running;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mult_q <= '0;
            end else if (accept_i) begin
               mult_q <= step_in_x;
            end else if (issue_vld_i) begin
               mult_q <= mult_q + step_q_x;
            end
         end

         assign mult_o         = mult_q;
         assign unused_running = ^issue_idx_i;
      end else begin : g_direct
         // Independent product per term: (index + 1) * step.
         logic signed [RES_W-1:0] k1_x;
         logic signed [RES_W-1:0] prod;
         logic                    unused_direct;

         assign k1_x          = $signed(RES_W'(issue_idx_i) + RES_W'(1));
         assign prod          = k1_x * step_q_x;
         assign mult_o        = prod;
         assign unused_direct = ^{clk, rst_n, accept_i, step_in_x, issue_vld_i};
      end
   endgenerate

endmodule

// File: rtl/stepacc_addpipe.sv
module stepacc_addpipe #(
   parameter int DATA_W  = 16,
   parameter int CNT_W   = 7,
   parameter int RES_W   = 23,
   parameter int ADD_LAT = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld_i,
   input  logic [DATA_W-1:0]       base_i,
   input  logic signed [RES_W-1:0] mult_i,
   input  logic [CNT_W-1:0]        idx_i,
   output logic                    out_vld_o,
   output logic signed [RES_W-1:0] out_sum_o,
   output logic [CNT_W-1:0]        out_idx_o
);

   localparam int EXT_W = RES_W - DATA_W;

   logic                    vld_r [ADD_LAT];
   logic signed [RES_W-1:0] sum_r [ADD_LAT];
   logic [CNT_W-1:0]        idx_r [ADD_LAT];
   logic signed [RES_W-1:0] base_x;

   assign base_x = {{EXT_W{base_i[DATA_W-1]}}, base_i};

   // Stage 0 performs the add; the remaining stages model the adder's latency.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_r[0] <= 1'b0;
      end else begin
         vld_r[0] <= in_vld_i;
      end
   end

   always_ff @(posedge clk) begin
      sum_r[0] <= base_x + mult_i;
      idx_r[0] <= idx_i;
   end

   generate
      for (genvar s = 1; s < ADD_LAT; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_r[s] <= 1'b0;
            end else begin
               vld_r[s] <= vld_r[s-1];
            end
         end

         always_ff @(posedge clk) begin
            sum_r[s] <= sum_r[s-1];
            idx_r[s] <= idx_r[s-1];
         end
      end
   endgenerate

   assign out_vld_o = vld_r[ADD_LAT-1];
   assign out_sum_o = sum_r[ADD_LAT-1];
   assign out_idx_o = idx_r[ADD_LAT-1];

endmodule

// File: rtl/const_step_accum.sv
module const_step_accum
   import stepacc_pkg::*;
#(
   parameter int         DATA_W    = 16,
   parameter int         MAX_COUNT = 64,
   parameter int         ADD_LAT   = 12,
   parameter mul_style_e MUL_STYLE = MUL_RUNNING,
   localparam int        CNT_W     = cnt_bits(MAX_COUNT),
   localparam int        RES_W     = DATA_W + CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [DATA_W-1:0] base_i,
   input  logic [DATA_W-1:0] step_i,
   output logic              res_valid_o,
   output logic [CNT_W-1:0]  res_index_o,
   output logic [RES_W-1:0]  res_data_o,
   output logic              busy_o,
   output logic              done_o
);

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
      assert (MAX_COUNT >= 1) else $error("MAX_COUNT must be at least 1");
      assert (ADD_LAT >= 1) else $error("ADD_LAT must be at least 1");
   end

   logic                    accept;
   logic [DATA_W-1:0]       base_q;
   logic [DATA_W-1:0]       step_q;
   logic [CNT_W-1:0]        cnt_q;
   logic                    issue_vld;
   logic [CNT_W-1:0]        issue_idx;
   logic signed [RES_W-1:0] mult;
   logic                    pipe_vld;
   logic signed [RES_W-1:0] pipe_sum;
   logic [CNT_W-1:0]        pipe_idx;
   logic                    drain_last;

   assign drain_last = pipe_vld && (pipe_idx == cnt_q - CNT_W'(1));

   stepacc_sequencer #(
      .DATA_W    (DATA_W),
      .MAX_COUNT (MAX_COUNT),
      .CNT_W     (CNT_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .count_i      (count_i),
      .base_i       (base_i),
      .step_i       (step_i),
      .drain_last_i (drain_last),
      .accept_o     (accept),
      .base_q_o     (base_q),
      .step_q_o     (step_q),
      .cnt_q_o      (cnt_q),
      .issue_vld_o  (issue_vld),
      .issue_idx_o  (issue_idx),
      .busy_o       (busy_o),
      .done_o       (done_o)
   );

   stepacc_multiple #(
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .RES_W     (RES_W),
      .MUL_STYLE (MUL_STYLE)
   ) u_mul (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept_i    (accept),
      .step_i      (step_i),
      .step_q_i    (step_q),
      .issue_vld_i (issue_vld),
      .issue_idx_i (issue_idx),
      .mult_o      (mult)
   );

   stepacc_addpipe #(
      .DATA_W  (DATA_W),
      .CNT_W   (CNT_W),
      .RES_W   (RES_W),
      .ADD_LAT (ADD_LAT)
   ) u_add (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld_i  (issue_vld),
      .base_i    (base_q),
      .mult_i    (mult),
      .idx_i     (issue_idx),
      .out_vld_o (pipe_vld),
      .out_sum_o (pipe_sum),
      .out_idx_o (pipe_idx)
   );

   assign res_valid_o = pipe_vld;
   assign res_index_o = pipe_idx;
   assign res_data_o  = pipe_sum;

endmodule

// File: rtl/const_step_accum_checker.sv
module const_step_accum_checker #(
   parameter int DATA_W    = 16,
   parameter int MAX_COUNT = 64,
   parameter int ADD_LAT   = 12,
   parameter int CNT_W     = 7,
   parameter int RES_W     = 23
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [CNT_W-1:0]  count_i,
   input logic [DATA_W-1:0] base_i,
   input logic [DATA_W-1:0] step_i,
   input logic              res_valid_o,
   input logic [CNT_W-1:0]  res_index_o,
   input logic [RES_W-1:0]  res_data_o,
   input logic              busy_o,
   input logic              done_o
);

   localparam int EXT_W = RES_W - DATA_W;

   logic              acc_seen;
   logic [DATA_W-1:0] base_c;
   logic [DATA_W-1:0] step_c;
   logic [CNT_W-1:0]  cnt_c;
   logic [15:0]       since_acc;
   logic signed [RES_W-1:0] exp_val;
   logic [CNT_W-1:0]  last_idx;

   assign acc_seen = start_i && !busy_o && (count_i != '0) && (count_i <= CNT_W'(MAX_COUNT));
   assign last_idx = cnt_c - CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_c    <= '0;
         step_c    <= '0;
         cnt_c     <= '0;
         since_acc <= '1;
      end else if (acc_seen) begin
         base_c    <= base_i;
         step_c    <= step_i;
         cnt_c     <= count_i;
         since_acc <= '0;
      end else if (since_acc != '1) begin
         since_acc <= since_acc + 16'd1;
      end
   end

   always_comb begin
      exp_val = $signed({{EXT_W{base_c[DATA_W-1]}}, base_c})
              + $signed(RES_W'(res_index_o) + RES_W'(1))
                * $signed({{EXT_W{step_c[DATA_W-1]}}, step_c});
   end

   assert_closed_form_R1: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> (res_data_o == exp_val));

   assert_back_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_index_o != last_idx)
      |=> (res_valid_o && res_index_o == CNT_W'($past(res_index_o) + CNT_W'(1))));

   // A restart taken while busy would reset index 0 without resetting since_acc (R4).
   assert_first_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_index_o == '0) |-> (since_acc == 16'(ADD_LAT)));

   assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(res_valid_o) && $past(res_index_o) == last_idx && !busy_o));

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !res_valid_o);

   assert_outputs_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, res_valid_o}));

endmodule

bind const_step_accum const_step_accum_checker #(
   .DATA_W    (DATA_W),
   .MAX_COUNT (MAX_COUNT),
   .ADD_LAT   (ADD_LAT),
   .CNT_W     (CNT_W),
   .RES_W     (RES_W)
) u_chk (.*);

// File: tb/const_step_accum_bench.sv
module const_step_accum_bench;

   localparam int DATA_W    = 16;
   localparam int MAX_COUNT = 64;
   localparam int LAT       = 12;
   localparam int CNT_W     = 7;
   localparam int RES_W     = 23;

   localparam int NV = 7;
   localparam int V_BASE [NV] = '{100, -3000, 32767, -32768, 0, 5, -1};
   localparam int V_STEP [NV] = '{7, 250, 32767, -32768, 0, -1, 1};
   localparam int V_CNT  [NV] = '{5, 12, 64, 64, 1, 20, 2};
   localparam bit V_PERT [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [CNT_W-1:0]  count_i = '0;
   logic [DATA_W-1:0] base_i = '0;
   logic [DATA_W-1:0] step_i = '0;
   logic              res_valid_o;
   logic [CNT_W-1:0]  res_index_o;
   logic [RES_W-1:0]  res_data_o;
   logic              busy_o;
   logic              done_o;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   const_step_accum #(
      .DATA_W    (DATA_W),
      .MAX_COUNT (MAX_COUNT),
      .ADD_LAT   (LAT)
   ) u_const_step_accum (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .count_i     (count_i),
      .base_i      (base_i),
      .step_i      (step_i),
      .res_valid_o (res_valid_o),
      .res_index_o (res_index_o),
      .res_data_o  (res_data_o),
      .busy_o      (busy_o),
      .done_o      (done_o)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_idle(input string req);
      check(res_valid_o == 1'b0, req, longint'(res_valid_o), 0);
      check(busy_o == 1'b0, req, longint'(busy_o), 0);
      check(done_o == 1'b0, req, longint'(done_o), 0);
   endtask

   // One run; compared each cycle against a recurrent reference sum.
   task automatic run_vec(input int b, input int s, input int n, input bit pert);
      longint acc;
      bit     exp_v;
      @(negedge clk);
      start_i = 1'b1;
      base_i  = DATA_W'(b);
      step_i  = DATA_W'(s);
      count_i = CNT_W'(n);
      @(negedge clk);
      start_i = 1'b0;
      acc = longint'(b);
      for (int j = 0; j <= LAT + n + 1; j++) begin
         exp_v = (j >= LAT) && (j < LAT + n);
         check(res_valid_o == exp_v, "R2/R3 valid", longint'(res_valid_o), longint'(exp_v));
         if (exp_v) begin
            acc = acc + longint'(s);
            check(res_index_o == CNT_W'(j - LAT), "R2 index",
                  longint'(res_index_o), longint'(j - LAT));
            check(longint'($signed(res_data_o)) == acc, "R1 data",
                  longint'($signed(res_data_o)), acc);
         end
         check(done_o == (j == LAT + n), "R5 done", longint'(done_o), longint'(j == LAT + n));
         check(busy_o == (j < LAT + n), "R5 busy", longint'(busy_o), longint'(j < LAT + n));
         if (pert && j == 2) begin
            // R4 and R7: restart attempt with different operands while busy.
            start_i = 1'b1;
            base_i  = DATA_W'(1234);
            step_i  = DATA_W'(-77);
            count_i = CNT_W'(3);
         end
         if (pert && j == 3) begin
            start_i = 1'b0;
         end
         @(negedge clk);
      end
   endtask

   task automatic bad_count(input int n);
      @(negedge clk);
      start_i = 1'b1;
      base_i  = DATA_W'(9);
      step_i  = DATA_W'(9);
      count_i = CNT_W'(n);
      @(negedge clk);
      start_i = 1'b0;
      for (int j = 0; j < LAT + 3; j++) begin
         check_idle("R6 ignored count");
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R8 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R8 after reset");

      for (int v = 0; v < NV; v++) begin
         run_vec(V_BASE[v], V_STEP[v], V_CNT[v], V_PERT[v]);
      end

      bad_count(0);
      bad_count(100);

      // R8: reset in the middle of a run stops all further results.
      @(negedge clk);
      start_i = 1'b1;
      base_i  = DATA_W'(50);
      step_i  = DATA_W'(3);
      count_i = CNT_W'(10);
      @(negedge clk);
      start_i = 1'b0;
      repeat (LAT + 2) @(negedge clk);
      check(res_valid_o == 1'b1, "R8 run active", longint'(res_valid_o), 1);
      rst_n = 1'b0;
      @(negedge clk);
      check_idle("R8 mid-run reset");
      rst_n = 1'b1;
      for (int j = 0; j < LAT + 12; j++) begin
         @(negedge clk);
         check_idle("R8 no residue");
      end

      // Fresh run after the reset still behaves.
      run_vec(-7, 3, 4, 1'b0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule